// File: doc/BRIEF.md
# Vectored-Interrupt Host Bus Slave

This block is the processor-facing side of a two-channel serial controller. It sits on an asynchronous, strobe-driven byte bus. A chip-select strobe, a direction bit and a 4-bit register index open a cycle. The block brings the strobes into its own clock domain and finishes every accepted cycle with an active-low transfer acknowledge. The data bus is modelled as separate in and out byte lanes with a drive enable. The acknowledge and the interrupt line are also modelled with their own enables, so the pads outside can build the three-state and open-drain behaviour.

The block holds an interrupt mask, an interrupt status register and a programmable interrupt vector. When a masked-in status bit is set, it pulls the interrupt line. A separate interrupt-acknowledge strobe asks for the vector. The block returns the vector and acknowledges that cycle only while an unmasked interrupt is pending. Otherwise it stays silent.

The block also holds the register state of the surrounding serial logic: an output port register, its configuration byte, channel enables and a timer run bit. It returns all of these to their idle levels on reset. The serial datapaths and the timer are not part of this block. They connect through stub status inputs and control outputs.

Top module: `hbus_irq_slave`

## Requirements
- R1: While reset is low: op_pins reads 0xFF, both txd bits read 1, and ctr_run, chan_en, irq_pull, dtack_oe and data_oe read 0. After reset, the vector register reads 0x0F. The mask, status, port, port-configuration, channel-control, timer-control and both channel-status registers read 0x00.
- R2: When no cycle is in progress, data_oe and dtack_oe are 0 and dtack_n is 1.
- R3: cs_n and iack_n each pass through two synchronising flops. dtack_oe rises with dtack_n low on the 4th rising clock edge after a strobe goes low. It is held while the strobe stays low. It is released on the 3rd rising edge after the strobe returns high.
- R4: A write (cs_n low, rd_wr 0) updates the addressed register on the acknowledge edge. The register map is: 0 channel A status (read-only), 1 channel B status (read-only), 2 channel control (bit 0 enables A, bit 1 enables B), 3 timer control (bit 0 runs the timer), 4 interrupt mask, 5 interrupt status (read-only), 6 interrupt vector, 7 port configuration, 8 output port. Indices 9 to 15 read 0x00 and ignore writes.
- R5: A read (rd_wr 1) presents the addressed register on data_out with data_oe 1 during the acknowledge. data_oe is never 1 without an asserted acknowledge, and it stays 0 for writes.
- R6: The interrupt status register captures isr_src on every clock edge. Reading index 5 returns these raw bits whatever the mask holds, and writes to index 5 have no effect.
- R7: irq_pull is 1 exactly when the status and mask registers share a set bit. It follows a change of isr_src one clock edge later.
- R8: An interrupt-acknowledge cycle with a pending unmasked interrupt presents the vector register with data_oe 1. It is acknowledged with the R3 timing.
- R9: An interrupt-acknowledge cycle with no pending unmasked interrupt never raises dtack_oe or data_oe.
- R10: If cs_n and iack_n fall together, the cycle is an interrupt acknowledge. It returns the vector, and the write it would otherwise carry is dropped.
- R11: op_pins is the bitwise inverse of the output port register. txd[i] carries tx_raw[i] while channel i is enabled and 1 otherwise. ctr_run follows timer-control bit 0, chan_en follows channel-control bits 1:0, and opcr_out follows the port-configuration register.
- R12: The channel-status registers capture sta_a_src and sta_b_src on every clock edge and are read at indices 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select strobe, active low |
| rd_wr | input | 1 | 1 selects a read, 0 selects a write |
| addr | input | 4 | Register index |
| data_in | input | 8 | Write data from the bus, bit 0 least significant |
| data_out | output | 8 | Read or vector data toward the bus |
| data_oe | output | 1 | Drive enable for data_out; 0 means high impedance |
| dtack_n | output | 1 | Transfer acknowledge level, active low |
| dtack_oe | output | 1 | Drive enable for the acknowledge; 0 means high impedance |
| iack_n | input | 1 | Interrupt-acknowledge strobe, active low |
| irq_pull | output | 1 | 1 pulls the open-drain interrupt line low |
| isr_src | input | 8 | Interrupt source levels |
| sta_a_src | input | 8 | Channel A status stub |
| sta_b_src | input | 8 | Channel B status stub |
| tx_raw | input | 2 | Serial transmit bits from the channel stubs |
| txd | output | 2 | Transmit lines, idle high |
| op_pins | output | 8 | Output port pins |
| opcr_out | output | 8 | Port configuration byte |
| chan_en | output | 2 | Channel enables |
| ctr_run | output | 1 | Timer run control |

## Verification
The bench applies every strobe at a falling clock edge. It then counts falling edges: the acknowledge is due at the 4th and must be gone at the 3rd falling edge after release. It also confirms that the acknowledge is still held at the 2nd falling edge after release and again two edges after it first appears. The capture into the status registers and the interrupt line are due one rising edge after an input change. They are sampled at the falling edge before that rising edge (expecting the old value) and at the falling edge after it. Register writes commit on the acknowledge edge, and the effect is read back in a later cycle.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned AW  = 4;
  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    CY_IDLE,
    CY_WAIT,
    CY_ACK,
    CY_IGN
  } cyc_state_e;

  localparam logic [AW-1:0] RA_STA_A  = 4'd0;
  localparam logic [AW-1:0] RA_STA_B  = 4'd1;
  localparam logic [AW-1:0] RA_CHCTL  = 4'd2;
  localparam logic [AW-1:0] RA_TMRCTL = 4'd3;
  localparam logic [AW-1:0] RA_IMR    = 4'd4;
  localparam logic [AW-1:0] RA_ISR    = 4'd5;
  localparam logic [AW-1:0] RA_IVR    = 4'd6;
  localparam logic [AW-1:0] RA_OPCR   = 4'd7;
  localparam logic [AW-1:0] RA_OPR    = 4'd8;

  // an interrupt is due when any status bit is enabled by its mask bit
  function automatic logic irq_due(logic [DW-1:0] stat, logic [DW-1:0] mask);
    return |(stat & mask);
  endfunction

  // port pins are the complement of the port register
  function automatic logic [DW-1:0] pin_level(logic [DW-1:0] opr);
    return ~opr;
  endfunction

  // idle transmit level is mark (1) whenever the channel is off
  function automatic logic line_level(logic enabled, logic raw);
    return enabled ? raw : 1'b1;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbi_cycle_ctl.sv
module hbi_cycle_ctl
  import hbi_pkg::*;
#(
  parameter int unsigned ACK_WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_seen,
  input  logic iack_seen,
  input  logic irq_pending,
  output logic ack_on,
  output logic cyc_iack,
  output logic wr_strobe
);
  localparam int unsigned CNT_W = (ACK_WAIT > 2) ? $clog2(ACK_WAIT - 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_WAIT - 2);

  cyc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             iack_q;
  logic             strobe;
  logic             last;
  logic             enter_ack;

  assign strobe    = cs_seen | iack_seen;
  assign last      = (cnt_q == CNT_LAST);
  assign enter_ack = (state_q == CY_WAIT) && strobe && last && (!iack_q || irq_pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CY_IDLE;
      cnt_q   <= '0;
      iack_q  <= 1'b0;
    end else begin
      unique case (state_q)
        CY_IDLE: if (strobe) begin
          state_q <= CY_WAIT;
          cnt_q   <= '0;
          iack_q  <= iack_seen;   // acknowledge strobe wins a tie
        end
        CY_WAIT: begin
          if (!strobe)       state_q <= CY_IDLE;
          else if (last)     state_q <= (iack_q && !irq_pending) ? CY_IGN : CY_ACK;
          else               cnt_q   <= cnt_q + CNT_W'(1);
        end
        CY_ACK, CY_IGN: if (!strobe) state_q <= CY_IDLE;
        default: state_q <= CY_IDLE;
      endcase
    end
  end

  assign ack_on    = (state_q == CY_ACK);
  assign cyc_iack  = iack_q;
  assign wr_strobe = enter_ack && !iack_q;
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
  import hbi_pkg::*;
#(
  parameter logic [DW-1:0] IVR_INIT = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   isr_src,
  input  logic [DW-1:0]   sta_a_src,
  input  logic [DW-1:0]   sta_b_src,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   imr_q,
  output logic [DW-1:0]   isr_q,
  output logic [DW-1:0]   ivr_q,
  output logic [DW-1:0]   opr_q,
  output logic [DW-1:0]   opcr_q,
  output logic [NCH-1:0]  chan_en_q,
  output logic            tmr_run_q
);
  logic [DW-1:0] sta_a_q;
  logic [DW-1:0] sta_b_q;

  // sampled status: refreshed every clock, cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q   <= '0;
      sta_a_q <= '0;
      sta_b_q <= '0;
    end else begin
      isr_q   <= isr_src;
      sta_a_q <= sta_a_src;
      sta_b_q <= sta_b_src;
    end
  end

  // host-writable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q     <= '0;
      ivr_q     <= IVR_INIT;
      opr_q     <= '0;
      opcr_q    <= '0;
      chan_en_q <= '0;
      tmr_run_q <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        RA_CHCTL:  chan_en_q <= wdata[NCH-1:0];
        RA_TMRCTL: tmr_run_q <= wdata[0];
        RA_IMR:    imr_q     <= wdata;
        RA_IVR:    ivr_q     <= wdata;
        RA_OPCR:   opcr_q    <= wdata;
        RA_OPR:    opr_q     <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      RA_STA_A:  rdata = sta_a_q;
      RA_STA_B:  rdata = sta_b_q;
      RA_CHCTL:  rdata = {{(DW-NCH){1'b0}}, chan_en_q};
      RA_TMRCTL: rdata = {{(DW-1){1'b0}}, tmr_run_q};
      RA_IMR:    rdata = imr_q;
      RA_ISR:    rdata = isr_q;
      RA_IVR:    rdata = ivr_q;
      RA_OPCR:   rdata = opcr_q;
      RA_OPR:    rdata = opr_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/hbus_irq_slave.sv
module hbus_irq_slave
  import hbi_pkg::*;
#(
  parameter int unsigned   SYNC_STAGES = 2,
  parameter int unsigned   ACK_WAIT    = 2,
  parameter logic [DW-1:0] IVR_INIT    = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  output logic             dtack_n,
  output logic             dtack_oe,
  input  logic             iack_n,
  output logic             irq_pull,
  input  logic [DW-1:0]    isr_src,
  input  logic [DW-1:0]    sta_a_src,
  input  logic [DW-1:0]    sta_b_src,
  input  logic [NCH-1:0]   tx_raw,
  output logic [NCH-1:0]   txd,
  output logic [DW-1:0]    op_pins,
  output logic [DW-1:0]    opcr_out,
  output logic [NCH-1:0]   chan_en,
  output logic             ctr_run
);
  logic [1:0]    strb_sync;
  logic          cs_seen;
  logic          iack_seen;
  logic          strobe_seen;
  logic          ack_on;
  logic          cyc_iack;
  logic          wr_strobe;
  logic          wr_ev;
  logic [DW-1:0] rdata;
  logic [DW-1:0] imr_q;
  logic [DW-1:0] isr_q;
  logic [DW-1:0] ivr_q;
  logic [DW-1:0] opr_q;
  logic [DW-1:0] opcr_q;
  logic [NCH-1:0] chan_en_q;
  logic          tmr_run_q;

  hbi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({iack_n, cs_n}),
    .q     (strb_sync)
  );

  assign cs_seen     = ~strb_sync[0];
  assign iack_seen   = ~strb_sync[1];
  assign strobe_seen = cs_seen | iack_seen;

  hbi_cycle_ctl #(.ACK_WAIT(ACK_WAIT)) u_cyc (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_seen     (cs_seen),
    .iack_seen   (iack_seen),
    .irq_pending (irq_pull),
    .ack_on      (ack_on),
    .cyc_iack    (cyc_iack),
    .wr_strobe   (wr_strobe)
  );

  assign wr_ev = wr_strobe && !rd_wr;

  hbi_regs #(.IVR_INIT(IVR_INIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_ev),
    .addr      (addr),
    .wdata     (data_in),
    .isr_src   (isr_src),
    .sta_a_src (sta_a_src),
    .sta_b_src (sta_b_src),
    .rdata     (rdata),
    .imr_q     (imr_q),
    .isr_q     (isr_q),
    .ivr_q     (ivr_q),
    .opr_q     (opr_q),
    .opcr_q    (opcr_q),
    .chan_en_q (chan_en_q),
    .tmr_run_q (tmr_run_q)
  );

  assign irq_pull = irq_due(isr_q, imr_q);

  assign data_out = cyc_iack ? ivr_q : rdata;
  assign data_oe  = ack_on && (cyc_iack || rd_wr);
  assign dtack_oe = ack_on;
  assign dtack_n  = ~ack_on;

  assign op_pins  = pin_level(opr_q);
  assign opcr_out = opcr_q;
  assign chan_en  = chan_en_q;
  assign ctr_run  = tmr_run_q;

  for (genvar c = 0; c < NCH; c++) begin : g_txd
    assign txd[c] = line_level(chan_en_q[c], tx_raw[c]);
  end
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker
  import hbi_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           strobe_seen,
  input logic           cyc_iack,
  input logic           wr_ev,
  input logic [DW-1:0]  isr_src,
  input logic [DW-1:0]  imr_q,
  input logic           irq_pull,
  input logic           dtack_n,
  input logic           dtack_oe,
  input logic           data_oe,
  input logic [DW-1:0]  op_pins,
  input logic [NCH-1:0] txd,
  input logic           ctr_run
);
  logic rst_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) rst_seen <= 1'b1;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n && rst_seen === 1'b1) begin
      reset_idle_chk: assert (op_pins == '1 && txd == '1 && !ctr_run && !dtack_oe && !data_oe)
        else $error("reset outputs not idle");
    end
  end

  // R5
  oe_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (dtack_oe && !dtack_n));

  // R2
  ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_oe |-> dtack_n);

  // R3
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_oe) |-> $past(strobe_seen));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack_oe && !strobe_seen) |=> !dtack_oe);

  // R9
  iack_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dtack_oe) && cyc_iack) |-> $past(irq_pull));

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((isr_src & imr_q) != '0) && !wr_ev) |=> irq_pull);

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((isr_src & imr_q) == '0) && !wr_ev) |=> !irq_pull);
endmodule

bind hbus_irq_slave hbi_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe_seen (strobe_seen),
  .cyc_iack    (cyc_iack),
  .wr_ev       (wr_ev),
  .isr_src     (isr_src),
  .imr_q       (imr_q),
  .irq_pull    (irq_pull),
  .dtack_n     (dtack_n),
  .dtack_oe    (dtack_oe),
  .data_oe     (data_oe),
  .op_pins     (op_pins),
  .txd         (txd),
  .ctr_run     (ctr_run)
);

// File: tb/hbus_irq_slave_tb_top.sv
module hbus_irq_slave_tb_top;
  // one time unit is 1 ns: 4-unit period gives 250 MHz
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       iack_n = 1'b1;
  logic       rd_wr = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] isr_src = '0;
  logic [7:0] sta_a_src = '0;
  logic [7:0] sta_b_src = '0;
  logic [1:0] tx_raw = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       dtack_n;
  logic       dtack_oe;
  logic       irq_pull;
  logic [1:0] txd;
  logic [7:0] op_pins;
  logic [7:0] opcr_out;
  logic [1:0] chan_en;
  logic       ctr_run;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  hbus_irq_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .dtack_n(dtack_n), .dtack_oe(dtack_oe), .iack_n(iack_n),
    .irq_pull(irq_pull), .isr_src(isr_src), .sta_a_src(sta_a_src),
    .sta_b_src(sta_b_src), .tx_raw(tx_raw), .txd(txd), .op_pins(op_pins),
    .opcr_out(opcr_out), .chan_en(chan_en), .ctr_run(ctr_run)
  );

  task automatic cmp(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one strobe cycle, started and observed on falling edges
  task automatic bus_cycle(input bit use_cs, input bit use_iack, input bit rd,
                           input logic [3:0] a, input logic [7:0] wd,
                           input bit expect_ack, input string req,
                           output logic [7:0] got);
    int first = 0;
    bit oe_at_ack = 1'b0;
    bit lvl_at_ack = 1'b1;
    bit any_oe = 1'b0;
    got = '0;
    @(negedge clk);
    cs_n = !use_cs; iack_n = !use_iack; rd_wr = rd; addr = a; data_in = wd;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (data_oe) any_oe = 1'b1;
      if (first == 0 && dtack_oe) begin
        first = n; got = data_out; oe_at_ack = data_oe; lvl_at_ack = dtack_n;
      end
    end
    if (expect_ack) begin
      cmp("R3", "ack edge count", 8'(first), 8'd4);
      cmp("R3", "dtack level", {7'd0, lvl_at_ack}, 8'd0);
      cmp("R3", "ack held", {7'd0, dtack_oe}, 8'd1);
      cmp(req, "data drive", {7'd0, oe_at_ack}, {7'd0, (rd || use_iack)});
    end else begin
      cmp(req, "no ack", 8'(first), 8'd0);
      cmp(req, "no drive", {7'd0, any_oe}, 8'd0);
    end
    cs_n = 1'b1; iack_n = 1'b1; rd_wr = 1'b1;
    repeat (2) @(negedge clk);
    if (expect_ack) cmp("R3", "ack before release", {7'd0, dtack_oe}, 8'd1);
    @(negedge clk);
    cmp("R3", "ack released", {7'd0, dtack_oe}, 8'd0);
    cmp("R2", "bus idle", {7'd0, data_oe}, 8'd0);
    cmp("R2", "dtack idle level", {7'd0, dtack_n}, 8'd1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] g;
    bus_cycle(1'b1, 1'b0, 1'b0, a, d, 1'b1, "R4", g);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [7:0] g;
    bus_cycle(1'b1, 1'b0, 1'b1, a, 8'h00, 1'b1, "R5", g);
    cmp(req, $sformatf("read idx %0d", a), g, exp);
  endtask

  task automatic t_reset_values;
    repeat (3) @(negedge clk);
    cmp("R1", "op_pins in reset", op_pins, 8'hFF);
    cmp("R1", "txd in reset", {6'd0, txd}, 8'h03);
    cmp("R1", "ctr_run in reset", {7'd0, ctr_run}, 8'h00);
    cmp("R1", "chan_en in reset", {6'd0, chan_en}, 8'h00);
    cmp("R1", "irq in reset", {7'd0, irq_pull}, 8'h00);
    cmp("R2", "dtack_oe in reset", {7'd0, dtack_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cmp("R2", "idle data_oe", {7'd0, data_oe}, 8'h00);
    rd_chk(4'd6, 8'h0F, "R1");
    rd_chk(4'd4, 8'h00, "R1");
    rd_chk(4'd5, 8'h00, "R1");
    rd_chk(4'd8, 8'h00, "R1");
    rd_chk(4'd7, 8'h00, "R1");
    rd_chk(4'd2, 8'h00, "R1");
    rd_chk(4'd3, 8'h00, "R1");
    rd_chk(4'd0, 8'h00, "R1");
  endtask

  task automatic t_regs;
    wr(4'd4, 8'h5A); rd_chk(4'd4, 8'h5A, "R4");
    wr(4'd6, 8'h3C); rd_chk(4'd6, 8'h3C, "R4");
    wr(4'd7, 8'h81); rd_chk(4'd7, 8'h81, "R4");
    cmp("R11", "opcr_out", opcr_out, 8'h81);
    wr(4'd12, 8'hFF); rd_chk(4'd12, 8'h00, "R4");
    wr(4'd4, 8'h00);
  endtask

  task automatic t_outputs;
    wr(4'd8, 8'h0F);
    cmp("R11", "op_pins", op_pins, 8'hF0);
    tx_raw = 2'b00;
    wr(4'd2, 8'h01);
    cmp("R11", "txd A on B off", {6'd0, txd}, 8'h02);
    cmp("R11", "chan_en", {6'd0, chan_en}, 8'h01);
    wr(4'd3, 8'h01);
    cmp("R11", "ctr_run", {7'd0, ctr_run}, 8'h01);
  endtask

  task automatic t_status;
    sta_a_src = 8'h33; sta_b_src = 8'hC4;
    rd_chk(4'd0, 8'h33, "R12");
    rd_chk(4'd1, 8'hC4, "R12");
  endtask

  task automatic t_isr_raw;
    isr_src = 8'hA5;
    rd_chk(4'd5, 8'hA5, "R6");
    cmp("R7", "masked-out irq", {7'd0, irq_pull}, 8'h00);
    wr(4'd5, 8'h00);
    rd_chk(4'd5, 8'hA5, "R6");
    isr_src = 8'h00;
  endtask

  task automatic t_irq;
    wr(4'd4, 8'h10);
    @(negedge clk);
    isr_src = 8'h10;
    cmp("R7", "irq before edge", {7'd0, irq_pull}, 8'h00);
    @(negedge clk);
    cmp("R7", "irq after edge", {7'd0, irq_pull}, 8'h01);
    isr_src = 8'h01;
    @(negedge clk);
    cmp("R7", "irq masked source", {7'd0, irq_pull}, 8'h00);
    isr_src = 8'h00;
  endtask

  task automatic t_iack_hit;
    logic [7:0] g;
    wr(4'd6, 8'h42);
    wr(4'd4, 8'h01);
    isr_src = 8'h01;
    @(negedge clk);
    bus_cycle(1'b0, 1'b1, 1'b1, 4'd0, 8'h00, 1'b1, "R8", g);
    cmp("R8", "vector", g, 8'h42);
  endtask

  task automatic t_iack_miss;
    logic [7:0] g;
    isr_src = 8'h00;
    repeat (2) @(negedge clk);
    bus_cycle(1'b0, 1'b1, 1'b1, 4'd0, 8'h00, 1'b0, "R9", g);
  endtask

  task automatic t_priority;
    logic [7:0] g;
    isr_src = 8'h01;
    repeat (2) @(negedge clk);
    bus_cycle(1'b1, 1'b1, 1'b0, 4'd6, 8'h99, 1'b1, "R10", g);
    cmp("R10", "vector wins", g, 8'h42);
    rd_chk(4'd6, 8'h42, "R10");
    isr_src = 8'h00;
  endtask

  task automatic t_reset_again;
    wr(4'd4, 8'hFF);
    wr(4'd8, 8'hFF);
    wr(4'd2, 8'h03);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R1", "op_pins after reset", op_pins, 8'hFF);
    cmp("R1", "txd after reset", {6'd0, txd}, 8'h03);
    cmp("R1", "ctr_run after reset", {7'd0, ctr_run}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk(4'd4, 8'h00, "R1");
    rd_chk(4'd6, 8'h0F, "R1");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    t_reset_values;
    t_regs;
    t_outputs;
    t_status;
    t_isr_raw;
    t_irq;
    t_iack_hit;
    t_iack_miss;
    t_priority;
    t_reset_again;
    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary;
      $finish;
    end
  end
endmodule